// File: doc/BRIEF.md
# Pulse-Position Bit Demodulator and Frame Timing Controller

This block sits behind a preamble detector in a 1090 MHz surveillance receiver. When the detector signals that the first data bit starts, the block takes over the frame. It recovers each data bit from a stream of magnitude samples by comparing the energy in the early half and the late half of each 1 us bit cell. The bits come out one at a time with a valid strobe, and they are also collected in a 112-bit message register.

A timing state machine controls the frame from start to end. It clears the datapath before the first bit and tells a downstream checksum unit when to start. It reads the first five bits as the message format as they arrive and uses them to pick a 56-bit or a 112-bit frame. After the last bit it tells the checksum unit to read out its result, and on the next cycle it raises a frame-done pulse. A bit whose two half-bit sums lie close together is marked as low-confidence, using a threshold supplied on an input.

Top module: `ppm_bit_demod`

## Requirements
- R1: After reset, every output is zero and the block waits in idle for a start strobe.
- R2: A start strobe seen in idle makes `crc_start_o` high for exactly one cycle, in the cycle after the strobe. From the cycle after that, `msg_o` and `msg_bits_o` read zero.
- R3: Each bit cell takes SAMPLES_PER_HALF_BIT accepted samples into an early sum and the next SAMPLES_PER_HALF_BIT accepted samples into a late sum. The bit is 1 when the early sum is strictly greater than the late sum, otherwise 0 (a tie gives 0).
- R4: A cycle with `smp_vld_i` low adds nothing to either sum and does not advance the sample position.
- R5: `bit_vld_o` is high for one cycle, in the cycle after the last sample of a bit cell. `bit_o` carries that bit, and bits come out in the order they were sent.
- R6: `bit_weak_o` is 1 with a bit when the absolute difference between its early and late sums is less than `margin_i`.
- R7: Each new bit enters `msg_o[0]` and the earlier bits move up one place. After a 56-bit frame the first bit is at `msg_o[55]`; after a 112-bit frame it is at `msg_o[111]`.
- R8: The first five bits, read with the first-received bit as the MSB, form the format value. A value of 16 or more sets `msg_bits_o` to 112, any other value sets it to 56. The new value shows in the cycle after the fifth bit's last sample, and `msg_bits_o` is 0 before that.
- R9: After the last bit of the frame, `crc_read_o` is high for one cycle. `frame_done_o` is high for one cycle in the cycle after that. The block is back in idle in the cycle after frame-done.
- R10: A start strobe seen while a frame is in progress does not restart the frame and does not pulse `crc_start_o`.
- R11: Samples that arrive after the last bit of a frame, and samples that arrive in idle, produce no bit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-data strobe from the preamble detector |
| smp_vld_i | input | 1 | Sample strobe; high when `smp_mag_i` holds a sample |
| smp_mag_i | input | MAG_W | Magnitude sample |
| margin_i | input | SUM_W | Low-confidence threshold on the half-sum difference |
| bit_o | output | 1 | Demodulated bit |
| bit_vld_o | output | 1 | One-cycle strobe for `bit_o` |
| bit_weak_o | output | 1 | Low-confidence flag for `bit_o` |
| msg_o | output | 112 | Message shift register |
| msg_bits_o | output | LEN_W | Frame length in bits: 0 until decoded, then 56 or 112 |
| crc_start_o | output | 1 | Tells the checksum unit to clear and start |
| crc_read_o | output | 1 | Tells the checksum unit to read out its result |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench targets three boundaries: the format values 15 and 16 on either side of the length threshold, equal half-sums, and full-scale samples in both halves. A design with the wrong threshold or comparison would give a frame of the wrong length, and the end-of-frame strobes would arrive 56 bits early or late. Sample gaps inside a bit cell and a second start strobe in the middle of a frame are also driven. A design that counted a gap as a sample, or that restarted on the second strobe, would shift every later bit or pulse the checksum start a second time. Samples keep arriving after the last bit. A design that did not stop at the end of the frame would emit stray bit strobes, and the scoreboard reports these as unexpected.

// File: rtl/ppm_demod_pkg.sv
package ppm_demod_pkg;

  localparam int unsigned SHORT_BITS   = 56;
  localparam int unsigned LONG_BITS    = 112;
  localparam int unsigned FMT_BITS     = 5;
  localparam int unsigned LONG_FMT_MIN = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_DATA,
    ST_CHECK,
    ST_DONE
  } frame_state_e;

endpackage

// File: rtl/ppm_half_integ.sv
module ppm_half_integ #(
  parameter int unsigned MAG_W = 12,
  parameter int unsigned SPH   = 4,
  parameter int unsigned SUM_W = MAG_W + $clog2(SPH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic [SUM_W-1:0] margin_i,
  output logic             dec_o,
  output logic             bit_o,
  output logic             weak_o
);

  localparam int unsigned CELL  = 2 * SPH;
  localparam int unsigned CNT_W = (CELL > 1) ? $clog2(CELL) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] early_q, late_q;
  logic [SUM_W-1:0] late_full, diff;
  logic             in_early;

  assign in_early  = cnt_q < CNT_W'(SPH);
  assign dec_o     = en_i && (cnt_q == CNT_W'(CELL - 1));
  // last sample of a cell always belongs to the late half
  assign late_full = late_q + SUM_W'(mag_i);
  assign bit_o     = early_q > late_full;
  assign diff      = bit_o ? (early_q - late_full) : (late_full - early_q);
  assign weak_o    = diff < margin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      early_q <= '0;
      late_q  <= '0;
    end else if (clr_i || dec_o) begin
      cnt_q   <= '0;
      early_q <= '0;
      late_q  <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (in_early) early_q <= early_q + SUM_W'(mag_i);
      else          late_q  <= late_q + SUM_W'(mag_i);
    end
  end

endmodule

// File: rtl/ppm_msg_reg.sv
module ppm_msg_reg
  import ppm_demod_pkg::*;
#(
  parameter int unsigned MSG_W = LONG_BITS,
  parameter int unsigned LEN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             bit_i,
  input  logic             fmt_tick_i,
  output logic [MSG_W-1:0] msg_o,
  output logic [LEN_W-1:0] len_o,
  output logic             long_o
);

  logic [MSG_W-1:0]    msg_q;
  logic [LEN_W-1:0]    len_q;
  logic                long_q;
  logic [FMT_BITS-1:0] fmt;
  logic                fmt_long;

  // format value completes with the bit being shifted in now
  assign fmt      = {msg_q[FMT_BITS-2:0], bit_i};
  assign fmt_long = fmt >= FMT_BITS'(LONG_FMT_MIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_q  <= '0;
      len_q  <= '0;
      long_q <= 1'b0;
    end else if (clr_i) begin
      msg_q  <= '0;
      len_q  <= '0;
      long_q <= 1'b0;
    end else if (shift_i) begin
      msg_q <= {msg_q[MSG_W-2:0], bit_i};
      if (fmt_tick_i) begin
        long_q <= fmt_long;
        len_q  <= fmt_long ? LEN_W'(LONG_BITS) : LEN_W'(SHORT_BITS);
      end
    end
  end

  assign msg_o  = msg_q;
  assign len_o  = len_q;
  assign long_o = long_q;

endmodule

// File: rtl/ppm_frame_fsm.sv
module ppm_frame_fsm
  import ppm_demod_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic dec_i,
  input  logic long_i,
  output logic clr_o,
  output logic data_o,
  output logic fmt_tick_o,
  output logic check_o,
  output logic done_o
);

  localparam int unsigned BCNT_W = $clog2(LONG_BITS + 1);

  frame_state_e     st_q, st_d;
  logic [BCNT_W-1:0] bcnt_q;
  logic              last_bit;

  assign last_bit   = dec_i && (bcnt_q == (long_i ? BCNT_W'(LONG_BITS - 1)
                                                  : BCNT_W'(SHORT_BITS - 1)));
  assign fmt_tick_o = dec_i && (bcnt_q == BCNT_W'(FMT_BITS - 1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_CLEAR;
      ST_CLEAR: st_d = ST_DATA;
      ST_DATA:  if (last_bit) st_d = ST_CHECK;
      ST_CHECK: st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bcnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_CLEAR) bcnt_q <= '0;
      else if (dec_i)       bcnt_q <= bcnt_q + BCNT_W'(1);
    end
  end

  assign clr_o  = st_q == ST_CLEAR;
  assign data_o = st_q == ST_DATA;
  assign check_o = st_q == ST_CHECK;
  assign done_o = st_q == ST_DONE;

endmodule

// File: rtl/ppm_bit_demod.sv
module ppm_bit_demod
  import ppm_demod_pkg::*;
#(
  parameter int unsigned MAG_W                = 12,
  parameter int unsigned SAMPLES_PER_HALF_BIT = 4,
  parameter int unsigned SUM_W                = MAG_W + $clog2(SAMPLES_PER_HALF_BIT) + 1,
  parameter int unsigned LEN_W                = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 smp_vld_i,
  input  logic [MAG_W-1:0]     smp_mag_i,
  input  logic [SUM_W-1:0]     margin_i,
  output logic                 bit_o,
  output logic                 bit_vld_o,
  output logic                 bit_weak_o,
  output logic [LONG_BITS-1:0] msg_o,
  output logic [LEN_W-1:0]     msg_bits_o,
  output logic                 crc_start_o,
  output logic                 crc_read_o,
  output logic                 frame_done_o
);

  logic clr, data_act, dec, dec_bit, dec_weak, fmt_tick, is_long;
  logic bit_q, vld_q, weak_q;

  ppm_frame_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .dec_i      (dec),
    .long_i     (is_long),
    .clr_o      (clr),
    .data_o     (data_act),
    .fmt_tick_o (fmt_tick),
    .check_o    (crc_read_o),
    .done_o     (frame_done_o)
  );

  ppm_half_integ #(
    .MAG_W (MAG_W),
    .SPH   (SAMPLES_PER_HALF_BIT),
    .SUM_W (SUM_W)
  ) i_integ (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .en_i     (data_act && smp_vld_i),
    .mag_i    (smp_mag_i),
    .margin_i (margin_i),
    .dec_o    (dec),
    .bit_o    (dec_bit),
    .weak_o   (dec_weak)
  );

  ppm_msg_reg #(
    .MSG_W (LONG_BITS),
    .LEN_W (LEN_W)
  ) i_msg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .shift_i    (dec),
    .bit_i      (dec_bit),
    .fmt_tick_i (fmt_tick),
    .msg_o      (msg_o),
    .len_o      (msg_bits_o),
    .long_o     (is_long)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= 1'b0;
      vld_q  <= 1'b0;
      weak_q <= 1'b0;
    end else begin
      vld_q <= dec;
      if (dec) begin
        bit_q  <= dec_bit;
        weak_q <= dec_weak;
      end
    end
  end

  assign bit_o       = bit_q;
  assign bit_vld_o   = vld_q;
  assign bit_weak_o  = weak_q;
  assign crc_start_o = clr;

endmodule

// File: rtl/ppm_bit_demod_chk.sv
module ppm_bit_demod_chk #(
  parameter int unsigned LEN_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_vld_o,
  input logic             crc_start_o,
  input logic             crc_read_o,
  input logic             frame_done_o,
  input logic [LEN_W-1:0] msg_bits_o
);

  // R9: frame-done follows the checksum read-out by one cycle
  a_r9_done_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_read_o |=> frame_done_o);

  // R9: frame-done lasts one cycle and the block is back in idle
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o && !crc_read_o);

  // R9: the control strobes never overlap
  a_r9_ctrl_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({crc_start_o, crc_read_o, frame_done_o}));

  // R2: one-cycle checksum start, after which the length is cleared
  a_r2_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_start_o |=> !crc_start_o && (msg_bits_o == '0));

  // R5: bit strobe is a single-cycle pulse
  a_r5_vld_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |=> !bit_vld_o);

  // R8: length is only ever unknown, short or long
  a_r8_len_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_bits_o == '0) || (msg_bits_o == LEN_W'(56)) || (msg_bits_o == LEN_W'(112)));

  // R11: no bit comes out while the frame is being closed
  a_r11_no_bit_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> !bit_vld_o);

endmodule

bind ppm_bit_demod ppm_bit_demod_chk #(.LEN_W(LEN_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_vld_o    (bit_vld_o),
  .crc_start_o  (crc_start_o),
  .crc_read_o   (crc_read_o),
  .frame_done_o (frame_done_o),
  .msg_bits_o   (msg_bits_o)
);

// File: tb/test_ppm_bit_demod.sv
`timescale 1ns/1ps
module test_ppm_bit_demod;

  localparam int MAG_W = 12;
  localparam int SPH   = 4;
  localparam int SUM_W = MAG_W + $clog2(SPH) + 1;
  localparam int LEN_W = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              smp_vld_i = 1'b0;
  logic [MAG_W-1:0]  smp_mag_i = '0;
  logic [SUM_W-1:0]  margin_i = '0;
  logic              bit_o, bit_vld_o, bit_weak_o;
  logic [111:0]      msg_o;
  logic [LEN_W-1:0]  msg_bits_o;
  logic              crc_start_o, crc_read_o, frame_done_o;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct packed { logic b; logic w; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  ppm_bit_demod #(.MAG_W(MAG_W), .SAMPLES_PER_HALF_BIT(SPH)) i_ppm_bit_demod (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .smp_vld_i(smp_vld_i),
    .smp_mag_i(smp_mag_i), .margin_i(margin_i), .bit_o(bit_o),
    .bit_vld_o(bit_vld_o), .bit_weak_o(bit_weak_o), .msg_o(msg_o),
    .msg_bits_o(msg_bits_o), .crc_start_o(crc_start_o),
    .crc_read_o(crc_read_o), .frame_done_o(frame_done_o)
  );

  task automatic check(input bit ok, input string req, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic logic exp_bit(input int e, input int l);
    return (SPH * e) > (SPH * l);
  endfunction

  function automatic logic exp_weak(input int e, input int l);
    int d;
    d = SPH * e - SPH * l;
    if (d < 0) d = -d;
    return d < int'(margin_i);
  endfunction

  // scoreboard monitor: R3 R5 R6 R11
  always @(negedge clk) begin
    if (rst_n && bit_vld_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", $sformatf("stray bit actual=%0b expected none", bit_o));
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(bit_o == e.b, "R3 R5", $sformatf("bit actual=%0b expected=%0b", bit_o, e.b));
        check(bit_weak_o == e.w, "R6", $sformatf("weak actual=%0b expected=%0b", bit_weak_o, e.w));
      end
    end
  end

  // one bit cell; optional sample gap (R4) and start pulse (R10)
  task automatic drive_bit(input int e, input int l, input bit gap,
                           input bit pstart, input int chk_len);
    exp_t x;
    x.b = exp_bit(e, l);
    x.w = exp_weak(e, l);
    exp_q.push_back(x);
    for (int i = 0; i < 2 * SPH; i++) begin
      if (gap && i == 1) begin
        @(negedge clk);
        smp_vld_i = 1'b0;
        smp_mag_i = '1;
        start_i   = 1'b0;
      end
      @(negedge clk);
      if (i == 0 && chk_len != 0)
        check(int'(msg_bits_o) == chk_len, "R8",
              $sformatf("msg_bits actual=%0d expected=%0d", msg_bits_o, chk_len));
      smp_vld_i = 1'b1;
      smp_mag_i = MAG_W'((i < SPH) ? e : l);
      start_i   = pstart && (i == 0);
    end
  endtask

  // mode 0 strong, 1 weak/ties/gaps, 2 full scale + mid-frame start
  task automatic run_frame(input logic [111:0] bits, input int mode);
    int             len;
    logic [111:0]   exp_msg;
    int             e, l;
    logic           d;
    len     = (bits[111:107] >= 5'd16) ? 112 : 56;
    exp_msg = '0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(crc_start_o == 1'b1, "R2", $sformatf("crc_start actual=%0b expected=1", crc_start_o));
    @(negedge clk);
    check(crc_start_o == 1'b0, "R2", $sformatf("crc_start actual=%0b expected=0", crc_start_o));
    check(msg_o == '0, "R2 R7", $sformatf("msg not cleared actual=%h", msg_o));
    check(msg_bits_o == '0, "R2 R8", $sformatf("msg_bits actual=%0d expected=0", msg_bits_o));
    for (int i = 0; i < len; i++) begin
      d = bits[111 - i];
      case (mode)
        0: begin e = d ? 3000 : 100; l = d ? 100 : 3000; end
        1: if (i >= 5 && i % 7 == 3) begin e = 700; l = 700; end
           else begin e = d ? 900 : 880; l = d ? 880 : 900; end
        default: begin e = d ? 4095 : 0; l = d ? 0 : 4095; end
      endcase
      drive_bit(e, l, (mode == 1) && (i % 5 == 2), (mode == 2) && (i == 20),
                (i == 5) ? len : 0);
      exp_msg = {exp_msg[110:0], exp_bit(e, l)};
    end
    // keep samples flowing through the end of the frame (R11)
    @(negedge clk);
    smp_mag_i = MAG_W'(2000);
    check(crc_read_o == 1'b1, "R9", $sformatf("crc_read actual=%0b expected=1", crc_read_o));
    check(frame_done_o == 1'b0, "R9", $sformatf("done actual=%0b expected=0", frame_done_o));
    @(negedge clk);
    check(frame_done_o == 1'b1, "R9", $sformatf("done actual=%0b expected=1", frame_done_o));
    check(crc_read_o == 1'b0, "R9", $sformatf("crc_read actual=%0b expected=0", crc_read_o));
    check(msg_o == exp_msg, "R7", $sformatf("msg actual=%h expected=%h", msg_o, exp_msg));
    check(int'(msg_bits_o) == len, "R8",
          $sformatf("msg_bits actual=%0d expected=%0d", msg_bits_o, len));
    @(negedge clk);
    check(frame_done_o == 1'b0, "R9", $sformatf("done actual=%0b expected=0", frame_done_o));
    check(crc_start_o == 1'b0, "R10", $sformatf("crc_start actual=%0b expected=0", crc_start_o));
    repeat (2 * SPH + 3) @(negedge clk);
    smp_vld_i = 1'b0;
    check(exp_q.size() == 0, "R5", $sformatf("bits missing actual=%0d expected=0", exp_q.size()));
    check(msg_o == exp_msg, "R11", $sformatf("msg changed in idle actual=%h", msg_o));
  endtask

  function automatic logic [111:0] mk_frame(input logic [4:0] fmt, input int seed);
    logic [127:0] p;
    p = {4{32'hA5C3_19E7 ^ 32'(seed * 32'h9E37_79B9)}};
    p = p ^ (p >> 7) ^ (p << 13);
    return {fmt, p[106:0]};
  endfunction

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bit_vld_o == 0 && bit_o == 0 && bit_weak_o == 0 && msg_o == '0 &&
          msg_bits_o == '0 && crc_start_o == 0 && crc_read_o == 0 && frame_done_o == 0,
          "R1", "outputs not zero in reset actual=nonzero expected=0");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(crc_start_o == 1'b0 && frame_done_o == 1'b0, "R1", "not idle after reset actual=busy expected=idle");

    margin_i = SUM_W'(100);
    run_frame(mk_frame(5'd17, 1), 0);   // long, strong
    run_frame(mk_frame(5'd5, 2), 1);    // short, weak bits, ties, gaps
    run_frame(mk_frame(5'd15, 3), 2);   // boundary below threshold, full scale
    run_frame(mk_frame(5'd16, 4), 2);   // boundary at threshold, restart attempt
    margin_i = '0;
    run_frame(mk_frame(5'd24, 5), 1);   // long, no margin: never weak

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule